// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Fetch Unit

This block sits beside the execution core of a 16-bit processor with a 20-bit physical address space and decides which interrupt or exception is taken when an instruction finishes. It watches an edge-triggered non-maskable pin, a level-sensitive maskable request, and internal exception requests raised by the core. Those internal requests are divide error, single step, breakpoint (the one-byte CCh opcode), overflow and a software interrupt that carries its own type byte. When the core signals an instruction boundary, the unit picks one winner and turns it into an 8-bit type number.

Once a source is accepted, the unit clears the interrupt-enable and trap flags. It pulses a save strobe so the core pushes flags and the return address. It then reads two 16-bit words from the vector table, which lives at the bottom of memory with four bytes per entry. The word at type×4 becomes the new instruction pointer and the word at type×4+2 becomes the new code segment. Both are presented together with a one-cycle valid pulse. The memory port returns read data on the cycle after the read is issued.

Top module: `intr_vector_unit`

## Requirements
- R1: After reset, busy, save_stb, mem_rd and vec_valid are low, if_flag and tf_flag are 0, and no non-maskable event is pending.
- R2: A source is accepted only in a cycle where instr_done is high and the unit is idle. An instr_done with nothing pending starts no sequence.
- R3: Among simultaneous sources, the winner and its type are chosen in this order: divide error (type 0), then software interrupt (type = swi_type), then breakpoint (type 3), then overflow (type 4), then the pending non-maskable event (type 2), then the enabled maskable request (type = intr_type sampled at acceptance), then single step (type 1, taken when tf_flag is 1).
- R4: A rising edge on nmi_pin is latched until it is serviced, so a one-cycle pulse between boundaries is still taken. A pin held high after servicing does not trigger again.
- R5: intr_req is ignored while if_flag is 0.
- R6: On acceptance, if_flag and tf_flag are cleared, and this takes priority over a simultaneous flag load through flag_wr.
- R7: The accept cycle is followed by save_stb for one cycle. The next cycle reads byte address type×4, and the cycle after that reads type×4+2, both with mem_rd high.
- R8: Two cycles after the second read, vec_valid is high for one cycle. In that cycle new_ip holds the word returned for type×4, new_cs holds the word returned for type×4+2, and svc_type holds the type.
- R9: While busy is high, instr_done and exception requests are ignored and are not remembered.
- R10: Every vector read address lies in 00000h–003FFh. Type FFh reads 003FCh and 003FEh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction has completed (boundary) |
| exc_div | input | 1 | Divide error, valid with instr_done |
| exc_swi | input | 1 | Software interrupt, valid with instr_done |
| swi_type | input | 8 | Type byte of the software interrupt |
| exc_brk | input | 1 | Breakpoint opcode executed, valid with instr_done |
| exc_ovf | input | 1 | Overflow trap, valid with instr_done |
| nmi_pin | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_req | input | 1 | Maskable request, level sensitive |
| intr_type | input | 8 | Type number for the maskable request |
| flag_wr | input | 1 | Load if_flag and tf_flag from the next two inputs |
| flag_if_d | input | 1 | New interrupt-enable value |
| flag_tf_d | input | 1 | New trap (single step) value |
| if_flag | output | 1 | Interrupt-enable flag |
| tf_flag | output | 1 | Trap flag |
| busy | output | 1 | A service sequence is in progress |
| save_stb | output | 1 | Push flags and return address now |
| mem_rd | output | 1 | Vector table read request |
| mem_addr | output | 20 | Byte address of the vector word |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| vec_valid | output | 1 | new_ip, new_cs and svc_type are valid |
| new_ip | output | 16 | Handler instruction pointer |
| new_cs | output | 16 | Handler code segment |
| svc_type | output | 8 | Type number being serviced |

## Verification
The bench presents every exception together and then removes the winner one at a time. A priority encoder with a swapped branch would return the wrong type there. Non-maskable handling is tested three ways: a one-cycle pulse far from any boundary, which a level-sampled design would miss; a pin left high after service, which a level-sensitive design would take again; and a clash with an enabled maskable request, which must lose. A maskable request with the enable flag clear must leave the unit idle, and a re-raised request after a flag reload must then win over single step. Type FFh checks the top of the table for address truncation. A boundary driven in the middle of a sequence must be dropped rather than queued.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int IVU_TYPE_W = 8;
  localparam int IVU_WORD_W = 16;
  localparam int IVU_ADDR_W = 20;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_DIV, SRC_SWI, SRC_BRK, SRC_OVF, SRC_NMI, SRC_INTR, SRC_STEP
  } src_e;

  localparam logic [IVU_TYPE_W-1:0] TY_DIV  = 8'd0;
  localparam logic [IVU_TYPE_W-1:0] TY_STEP = 8'd1;
  localparam logic [IVU_TYPE_W-1:0] TY_NMI  = 8'd2;
  localparam logic [IVU_TYPE_W-1:0] TY_BRK  = 8'd3;
  localparam logic [IVU_TYPE_W-1:0] TY_OVF  = 8'd4;
endpackage

// File: rtl/ivu_nmi_latch.sv
module ivu_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = pin & ~prev_q;

  // prev resets high so a pin already high at reset is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= pin;
      if (rise)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio
  import ivu_pkg::*;
#(
  parameter int TYPE_W = IVU_TYPE_W
) (
  input  logic              exc_div,
  input  logic              exc_swi,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              exc_brk,
  input  logic              exc_ovf,
  input  logic              nmi_pend,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic              if_flag,
  input  logic              tf_flag,
  output src_e              src,
  output logic [TYPE_W-1:0] type_num,
  output logic              any
);
  always_comb begin
    src      = SRC_NONE;
    type_num = '0;
    if (exc_div) begin
      src = SRC_DIV;  type_num = TY_DIV;
    end else if (exc_swi) begin
      src = SRC_SWI;  type_num = swi_type;
    end else if (exc_brk) begin
      src = SRC_BRK;  type_num = TY_BRK;
    end else if (exc_ovf) begin
      src = SRC_OVF;  type_num = TY_OVF;
    end else if (nmi_pend) begin
      src = SRC_NMI;  type_num = TY_NMI;
    end else if (intr_req && if_flag) begin
      src = SRC_INTR; type_num = intr_type;
    end else if (tf_flag) begin
      src = SRC_STEP; type_num = TY_STEP;
    end
  end

  assign any = (src != SRC_NONE);
endmodule

// File: rtl/ivu_fetch_seq.sv
module ivu_fetch_seq
  import ivu_pkg::*;
#(
  parameter int TYPE_W = IVU_TYPE_W,
  parameter int WORD_W = IVU_WORD_W,
  parameter int ADDR_W = IVU_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TYPE_W-1:0] type_in,
  output logic              busy,
  output logic              save_stb,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              vec_valid,
  output logic [WORD_W-1:0] new_ip,
  output logic [WORD_W-1:0] new_cs,
  output logic [TYPE_W-1:0] svc_type
);
  localparam int PAD_W = ADDR_W - TYPE_W - 2;

  typedef enum logic [2:0] {S_IDLE, S_SAVE, S_FLO, S_FHI, S_FIN} st_e;
  st_e st_q;

  // byte address of the low (hi=0) or high (hi=1) word of an entry
  function automatic logic [ADDR_W-1:0] vec_addr(input logic [TYPE_W-1:0] t,
                                                  input logic hi);
    return {{PAD_W{1'b0}}, t, hi, 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      svc_type  <= '0;
      new_ip    <= '0;
      new_cs    <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          svc_type <= type_in;
          st_q     <= S_SAVE;
        end
        S_SAVE: st_q <= S_FLO;
        S_FLO:  st_q <= S_FHI;
        S_FHI: begin
          new_ip <= mem_rdata;
          st_q   <= S_FIN;
        end
        S_FIN: begin
          new_cs    <= mem_rdata;
          vec_valid <= 1'b1;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign save_stb = (st_q == S_SAVE);
  assign mem_rd   = (st_q == S_FLO) || (st_q == S_FHI);
  assign mem_addr = vec_addr(svc_type, st_q == S_FHI);
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
  import ivu_pkg::*;
#(
  parameter int TYPE_W = IVU_TYPE_W,
  parameter int WORD_W = IVU_WORD_W,
  parameter int ADDR_W = IVU_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              exc_div,
  input  logic              exc_swi,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              exc_brk,
  input  logic              exc_ovf,
  input  logic              nmi_pin,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic              flag_wr,
  input  logic              flag_if_d,
  input  logic              flag_tf_d,
  output logic              if_flag,
  output logic              tf_flag,
  output logic              busy,
  output logic              save_stb,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              vec_valid,
  output logic [WORD_W-1:0] new_ip,
  output logic [WORD_W-1:0] new_cs,
  output logic [TYPE_W-1:0] svc_type
);
  // named internal events, observed by the bound checker
  logic              nmi_pend;
  logic              nmi_clr;
  logic              accept;
  logic              any_pend;
  src_e              src_sel;
  logic [TYPE_W-1:0] win_type;

  ivu_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .clr(nmi_clr), .pend(nmi_pend)
  );

  ivu_prio #(.TYPE_W(TYPE_W)) u_prio (
    .exc_div(exc_div), .exc_swi(exc_swi), .swi_type(swi_type),
    .exc_brk(exc_brk), .exc_ovf(exc_ovf), .nmi_pend(nmi_pend),
    .intr_req(intr_req), .intr_type(intr_type),
    .if_flag(if_flag), .tf_flag(tf_flag),
    .src(src_sel), .type_num(win_type), .any(any_pend)
  );

  assign accept  = instr_done & ~busy & any_pend;
  assign nmi_clr = accept & (src_sel == SRC_NMI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_flag <= 1'b0;
      tf_flag <= 1'b0;
    end else if (accept) begin
      if_flag <= 1'b0;
      tf_flag <= 1'b0;
    end else if (flag_wr) begin
      if_flag <= flag_if_d;
      tf_flag <= flag_tf_d;
    end
  end

  ivu_fetch_seq #(.TYPE_W(TYPE_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .type_in(win_type),
    .busy(busy), .save_stb(save_stb), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .vec_valid(vec_valid), .new_ip(new_ip),
    .new_cs(new_cs), .svc_type(svc_type)
  );
endmodule

// File: rtl/ivu_checker.sv
module ivu_checker
  import ivu_pkg::*;
#(
  parameter int ADDR_W = IVU_ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input src_e              src_sel,
  input logic              busy,
  input logic              save_stb,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              vec_valid,
  input logic              if_flag,
  input logic              tf_flag,
  input logic              nmi_pend,
  input logic              nmi_clr
);
  // R2 / R9: nothing is taken while a sequence runs
  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R7: save strobe follows acceptance, then the low-word read
  p_save_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> save_stb);
  p_low_read_after_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save_stb |=> (mem_rd && !mem_addr[1]));

  // R6: both flags are clear once a source has been taken
  p_flags_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!if_flag && !tf_flag));

  // R5: the maskable source only wins with the enable flag set
  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && src_sel == SRC_INTR) |-> if_flag);

  // R4: a latched edge stays until serviced
  p_nmi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_clr) |=> nmi_pend);

  // R10: reads stay inside the vector table
  p_table_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[ADDR_W-1:10] == '0));

  // R8: strobe, reads and result are never simultaneous
  p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_stb, mem_rd, vec_valid}));
endmodule

bind intr_vector_unit ivu_checker #(.ADDR_W(ADDR_W)) u_ivu_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .src_sel(src_sel),
  .busy(busy), .save_stb(save_stb), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .vec_valid(vec_valid), .if_flag(if_flag), .tf_flag(tf_flag),
  .nmi_pend(nmi_pend), .nmi_clr(nmi_clr)
);

// File: tb/intr_vector_unit_tb_top.sv
`timescale 1ns/1ps
module intr_vector_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 0, exc_div = 0, exc_swi = 0, exc_brk = 0, exc_ovf = 0;
  logic [7:0]  swi_type = 8'h00, intr_type = 8'h00;
  logic        nmi_pin = 0, intr_req = 0;
  logic        flag_wr = 0, flag_if_d = 0, flag_tf_d = 0;
  logic        if_flag, tf_flag, busy, save_stb, mem_rd, vec_valid;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata = 16'h0000;
  logic [15:0] new_ip, new_cs;
  logic [7:0]  svc_type;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #2.5 clk = ~clk;

  intr_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .exc_div(exc_div),
    .exc_swi(exc_swi), .swi_type(swi_type), .exc_brk(exc_brk), .exc_ovf(exc_ovf),
    .nmi_pin(nmi_pin), .intr_req(intr_req), .intr_type(intr_type),
    .flag_wr(flag_wr), .flag_if_d(flag_if_d), .flag_tf_d(flag_tf_d),
    .if_flag(if_flag), .tf_flag(tf_flag), .busy(busy), .save_stb(save_stb),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .vec_valid(vec_valid), .new_ip(new_ip), .new_cs(new_cs), .svc_type(svc_type)
  );

  // vector table model: entry t holds ip {t^A0,t} and cs {t,t^3C}
  function automatic logic [15:0] exp_ip(input logic [7:0] t);
    return {t ^ 8'hA0, t};
  endfunction
  function automatic logic [15:0] exp_cs(input logic [7:0] t);
    return {t, t ^ 8'h3C};
  endfunction

  always @(posedge clk)
    if (mem_rd)
      mem_rdata <= mem_addr[1] ? exp_cs(mem_addr[9:2]) : exp_ip(mem_addr[9:2]);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected vec_valid", {24'h0, svc_type}, 32'h0);
      end else begin
        logic [7:0] t;
        string r;
        t = exp_q.pop_front();
        r = req_q.pop_front();
        chk(svc_type == t, {r, " R3 type"}, {24'h0, svc_type}, {24'h0, t});
        chk(new_ip == exp_ip(t), {r, " R8 ip"}, {16'h0, new_ip}, {16'h0, exp_ip(t)});
        chk(new_cs == exp_cs(t), {r, " R8 cs"}, {16'h0, new_cs}, {16'h0, exp_cs(t)});
      end
    end
  end

  // caller sets request inputs at a negedge, then calls run
  task automatic run(input logic [7:0] t, input string req, input bit poke);
    exp_q.push_back(t);
    req_q.push_back(req);
    instr_done = 1;
    @(negedge clk);
    instr_done = 0; exc_div = 0; exc_swi = 0; exc_brk = 0; exc_ovf = 0; flag_wr = 0;
    chk(save_stb && busy, "R7 save strobe", {31'h0, save_stb}, 32'h1);
    chk(!if_flag && !tf_flag, "R6 flags cleared", {30'h0, if_flag, tf_flag}, 32'h0);
    if (poke) begin instr_done = 1; exc_brk = 1; end
    @(negedge clk);
    instr_done = 0; exc_brk = 0;
    chk(mem_rd && mem_addr == {10'h0, t, 2'b00}, "R7 low read addr",
        {12'h0, mem_addr}, {22'h0, t, 2'b00});
    @(negedge clk);
    chk(mem_rd && mem_addr == {10'h0, t, 2'b10}, "R7 high read addr",
        {12'h0, mem_addr}, {22'h0, t, 2'b10});
    @(negedge clk);
    chk(!mem_rd && !vec_valid, "R8 gap cycle", {31'h0, vec_valid}, 32'h0);
    @(negedge clk);
    chk(vec_valid, "R8 valid pulse", {31'h0, vec_valid}, 32'h1);
    @(negedge clk);
    chk(!vec_valid && !busy, "R8 pulse one cycle", {31'h0, vec_valid}, 32'h0);
  endtask

  task automatic idle_boundary(input string req);
    instr_done = 1;
    @(negedge clk);
    instr_done = 0; exc_div = 0; exc_swi = 0; exc_brk = 0; exc_ovf = 0; flag_wr = 0;
    chk(!busy && !save_stb, req, {31'h0, busy}, 32'h0);
    @(negedge clk);
  endtask

  task automatic load_flags(input bit i, input bit tr);
    flag_wr = 1; flag_if_d = i; flag_tf_d = tr;
    @(negedge clk);
    flag_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !save_stb && !mem_rd && !vec_valid, "R1 idle outputs",
        {28'h0, busy, save_stb, mem_rd, vec_valid}, 32'h0);
    chk(!if_flag && !tf_flag, "R1 flags", {30'h0, if_flag, tf_flag}, 32'h0);

    // R2: boundary with nothing pending
    idle_boundary("R2 no source no sequence");

    // R3: all exceptions together, then drop winners one by one
    exc_div = 1; exc_swi = 1; swi_type = 8'h21; exc_brk = 1; exc_ovf = 1;
    run(8'h00, "R3 divide first", 0);
    exc_swi = 1; swi_type = 8'h21; exc_brk = 1; exc_ovf = 1;
    run(8'h21, "R3 swi second", 0);
    exc_brk = 1; exc_ovf = 1;
    run(8'h03, "R3 breakpoint third", 0);
    exc_ovf = 1;
    run(8'h04, "R3 overflow fourth", 0);

    // R10: top of table
    exc_swi = 1; swi_type = 8'hFF;
    run(8'hFF, "R10 type FF", 0);

    // R5: maskable request with enable clear is ignored
    intr_req = 1; intr_type = 8'h40;
    idle_boundary("R5 masked intr ignored");

    // R4: short non-maskable pulse between boundaries, outranks intr
    load_flags(1, 0);
    nmi_pin = 1; @(negedge clk); nmi_pin = 0;
    repeat (3) @(negedge clk);
    run(8'h02, "R4 nmi latched beats intr", 0);

    // R6: intr still high but enable cleared by entry
    idle_boundary("R6 enable cleared on entry");

    // R3: intr beats single step; flag load coinciding with accept loses (R6)
    load_flags(1, 1);
    flag_wr = 1; flag_if_d = 1; flag_tf_d = 1;
    run(8'h40, "R3 intr over step", 0);
    intr_req = 0;

    // R3: single step alone
    load_flags(0, 1);
    run(8'h01, "R3 single step", 0);

    // R4: held pin does not retrigger
    nmi_pin = 1; @(negedge clk); @(negedge clk);
    run(8'h02, "R4 nmi edge", 0);
    idle_boundary("R4 held pin no retrigger");
    nmi_pin = 0;

    // R9: boundary with a breakpoint during a sequence is dropped
    exc_div = 1;
    run(8'h00, "R9 divide with poke", 1);
    repeat (4) begin
      chk(!busy && !save_stb, "R9 poke not remembered", {31'h0, busy}, 32'h0);
      @(negedge clk);
    end
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule